// File: doc/BRIEF.md
# Bit-Serial Adder with Word Framing

This block adds two unsigned operands that arrive one bit per clock, least significant bit first, and produces the sum as a bit stream in the same order. Only one bit position is handled per cycle, so the hardware is a single full-adder slice, one carry register and one output register. The cost is latency: an N-bit word takes N cycles.

A framing input, `word_start`, goes high in the same cycle as the first (least significant) bit of every word. In that cycle the stored carry is ignored and a carry-in of zero is used. This lets words follow each other with no idle cycle between them. The carry out of a word's top bit is dropped when the next framing pulse arrives, so each word's result is its sum modulo 2^N. The output bit and a delayed copy of the framing pulse are registered and appear together one cycle after their inputs.

Top module: `serial_adder`

## Requirements
- R1: A synchronous active-low reset clears the stored carry, `sum_out` and `sum_start`. All three read 0 in the first cycle after a clock edge with `rst_n` low.
- R2: `sum_out` at clock edge k+1 is the XOR of `a_in`, `b_in` and the carry-in that was in effect at edge k.
- R3: In a cycle where `word_start` is 1, the carry-in is 0 regardless of the stored carry.
- R4: In a cycle where `word_start` is 0, the carry-in is the stored carry, which is the majority of the previous cycle's inputs and carry-in.
- R5: `sum_start` equals `word_start` delayed by one clock, so it marks the output bit that belongs to an input LSB.
- R6: Words streamed back to back, with `word_start` on every eighth cycle, each produce (a + b) mod 256 on the output, least significant bit first. The final carry of one word never reaches the next word.
- R7: When a word overflows its width, the carry out of its top bit is discarded. Example: 0xFF + 0x01 yields 0x00, and a following 0x00 + 0x00 word yields 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 1 | Serial bit of operand A, LSB first |
| b_in | input | 1 | Serial bit of operand B, LSB first |
| word_start | input | 1 | High on the LSB cycle of each word |
| sum_out | output | 1 | Registered serial sum bit |
| sum_start | output | 1 | Registered copy of `word_start`, aligned with `sum_out` |

## Verification
Every result is due exactly one clock after the bits that produce it. The output bit and the framing marker both pass through one register stage, while the carry affects only the following cycle's output. The bench drives inputs on the falling edge, which lands midway between rising edges. It samples the outputs just before the next falling edge, after exactly one rising edge has registered the bit. Each reassembled word is therefore complete one cycle after its top bit was driven. The bench checks that `sum_start` is high on the first bit of every reassembled word.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;
    typedef struct packed {
        logic carry;
        logic sum;
        logic start;
    } sadd_state_t;
endpackage

// File: rtl/sadd_slice.sv
module sadd_slice (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    always_comb begin
        s    = x ^ y ^ cin;
        cout = (x & y) | (x & cin) | (y & cin);
    end
endmodule

// File: rtl/serial_adder.sv
module serial_adder
    import serial_adder_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_in,
    input  logic b_in,
    input  logic word_start,
    output logic sum_out,
    output logic sum_start
);
    sadd_state_t st_d, st_q;
    logic cin_eff;
    logic s_w, c_w;

    sadd_slice u_slice (
        .x   (a_in),
        .y   (b_in),
        .cin (cin_eff),
        .s   (s_w),
        .cout(c_w)
    );

    always_comb begin
        cin_eff     = word_start ? 1'b0 : st_q.carry;
        st_d.carry  = c_w;
        st_d.sum    = s_w;
        st_d.start  = word_start;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_out   = st_q.sum;
    assign sum_start = st_q.start;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!sum_out && !sum_start && !st_q.carry));
    // R3
    a_r3_lsb_zero_cin: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |=> (sum_out == $past(a_in ^ b_in)));
    // R4
    a_r4_carry_used: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_start && a_in && b_in) |=> st_q.carry);
    // R5
    a_r5_start_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sum_start == $past(word_start)));
    // R2
    a_r2_no_carry_no_gen: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && !a_in && !b_in) |=> (!sum_out && !st_q.carry));
endmodule

// File: tb/test_serial_adder.sv
`timescale 1ns/1ps
module test_serial_adder;
    logic clk = 0, rst_n = 0, a_in = 0, b_in = 0, word_start = 0;
    logic sum_out, sum_start;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    serial_adder i_serial_adder (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .word_start(word_start), .sum_out(sum_out), .sum_start(sum_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one bit at negedge, sample just before next negedge
    task automatic step(input logic a, input logic b, input logic s,
                        output logic so, output logic ss);
        @(negedge clk);
        a_in = a; b_in = b; word_start = s;
        #4.9;
        so = sum_out; ss = sum_start;
    endtask

    // stream words back to back, check each
    task automatic stream(input string req, input logic [7:0] av[], input logic [7:0] bv[]);
        logic [7:0] got;
        logic so, ss;
        int n = av.size();
        for (int w = 0; w < n; w++) begin
            got = '0;
            for (int i = 0; i < 8; i++) begin
                step(av[w][i], bv[w][i], i == 0, so, ss);
                got[i] = so;
                if (i == 0) chk({req, " R5 start"}, ss, 1);
                else if (i == 1) chk({req, " R5 start"}, ss, 0);
            end
            chk({req, " R6 word"}, got, (av[w] + bv[w]) & 8'hFF);
        end
    endtask

    task automatic t_reset();
        logic so, ss;
        @(negedge clk); rst_n = 0; a_in = 1; b_in = 1; word_start = 1;
        @(negedge clk);
        chk("R1 sum", sum_out, 0);
        chk("R1 start", sum_start, 0);
        rst_n = 1;
        // carry from a 1+1 LSB, then R4 propagation: 0+0 no start gives carry
        step(1, 1, 1, so, ss); chk("R3 lsb sum", so, 0);
        step(0, 0, 0, so, ss); chk("R4 carry in", so, 1);
        // 1+1 then new word start 0+0: carry must be ignored
        step(1, 1, 0, so, ss); chk("R2 sum", so, 0);
        step(0, 0, 1, so, ss); chk("R3 carry ignored", so, 0);
        step(1, 0, 0, so, ss); chk("R2 single", so, 1);
    endtask

    task automatic t_overflow();
        stream("R7", '{8'hFF, 8'h00, 8'h80, 8'h01}, '{8'h01, 8'h00, 8'h80, 8'h00});
    endtask

    task automatic t_random();
        logic [7:0] av[], bv[];
        av = new[20]; bv = new[20];
        for (int k = 0; k < 20; k++) begin
            av[k] = 8'($urandom); bv[k] = 8'($urandom);
        end
        stream("R6 rand", av, bv);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_overflow();
        stream("R6 dir", '{8'h55, 8'hAA, 8'h7F}, '{8'hAA, 8'h55, 8'h01});
        t_random();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule